// File: doc/BRIEF.md
# Real-Mode Linear Address Former with Bit-20 Gate

This block turns a 16-bit segment value and a 16-bit offset into a linear address the legacy real-mode way. The segment is multiplied by sixteen and the offset is added. The raw sum can reach 0x10FFEF, which needs 21 bits. Whether bit 20 of that sum reaches the output is set by a gate. With the gate closed, any sum at or above 1 MiB folds back to the bottom of memory, as on a machine with 20 address lines. With the gate open, the full 21-bit sum is passed through.

The gate state is held in a one-byte system control register on a simple I/O bus at port address 0x92. A host writes bit 1 of that register to open or close the gate. Writing bit 0 as 1 asks for a fast reset, which the block signals as a pulse one clock wide. So software that only wants to change the gate writes bit 0 as 0. Reads of the port return the gate state. The address path is purely combinational, so the output follows the segment, the offset and the current gate state.

Top module: `rm_addr_unit`

## Requirements
- R1: With the gate open, `lin_addr_o` equals segment×16 + offset as a full 21-bit value, so FFFF:FFFF gives 0x10FFEF and FFFF:0010 gives 0x100000.
- R2: With the gate closed, `lin_addr_o[20]` is 0 and bits 19:0 equal the low 20 bits of segment×16 + offset, so FFFF:0010 gives 0x00000 and FFFF:FFFF gives 0x0FFEF.
- R3: After reset the gate is closed, `fast_rst_o` is 0, and a read of port 0x92 returns 0x00.
- R4: A write with `io_wr_i` high to I/O address 0x0092 loads write-data bit 1 into the gate, visible on `a20_en_o` and the address path from the clock edge that ends the write cycle.
- R5: A write to 0x0092 with write-data bit 0 equal to 1 drives `fast_rst_o` high for exactly the one cycle after the write edge. A write with bit 0 equal to 0 produces no pulse. Either way, bit 1 of the same write still sets the gate.
- R6: While `io_rd_i` is high and the address is 0x0092, `io_rdata_o` shows the gate state in bit 1, with bit 0 (the reset request) and bits 7:2 read as 0. Without such a read, `io_rdata_o` is 0x00.
- R7: Writes to any other I/O address leave the gate unchanged and cause no reset pulse. Write-data bits 7:2 have no effect.
- R8: Different pairs that name the same location give the same output, for example 0000:7C00 and 07C0:0000 both give 0x07C00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset value |
| io_addr_i | input | 16 | I/O port address |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data |
| lin_addr_o | output | 21 | Linear address |
| a20_en_o | output | 1 | Gate state for address bit 20 |
| fast_rst_o | output | 1 | Fast-reset pulse |

## Verification
The linear address and the read data are combinational, so the bench samples them one nanosecond after changing inputs on the falling edge, within the same cycle. A port write counts as done at the next rising edge. The bench samples gate state and reset pulse just after that edge, then checks again one cycle later that the pulse has dropped. Random address traffic is compared against a bench model of the gate that is updated only when a write to the port completes.

// File: rtl/rmau_pkg.sv
package rmau_pkg;
  localparam int SEG_W     = 16;
  localparam int OFF_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int LIN_W     = ((SEG_W + SEG_SHIFT) > OFF_W ? (SEG_W + SEG_SHIFT) : OFF_W) + 1;
  localparam int WRAP_BIT  = LIN_W - 1;
  localparam int IO_AW     = 16;
  localparam int IO_DW     = 8;
  localparam logic [IO_AW-1:0] CTL_PORT = 16'h0092;
  localparam int GATE_BIT  = 1;
  localparam int RSTRQ_BIT = 0;

  // Raw sum of shifted segment and offset, carry kept.
  function automatic logic [LIN_W-1:0] form_linear(input logic [SEG_W-1:0] seg,
                                                   input logic [OFF_W-1:0] off);
    logic [LIN_W-1:0] base;
    logic [LIN_W-1:0] disp;
    base = LIN_W'({seg, {SEG_SHIFT{1'b0}}});
    disp = LIN_W'(off);
    return base + disp;
  endfunction

  // Clear the top bit unless the gate is open.
  function automatic logic [LIN_W-1:0] gate_linear(input logic [LIN_W-1:0] raw,
                                                   input logic gate_open);
    logic [LIN_W-1:0] res;
    res = raw;
    if (!gate_open) res[WRAP_BIT] = 1'b0;
    return res;
  endfunction

  // Byte returned by a read of the control port.
  function automatic logic [IO_DW-1:0] ctl_readback(input logic gate_open);
    logic [IO_DW-1:0] b;
    b = '0;
    b[GATE_BIT] = gate_open;
    return b;
  endfunction
endpackage

// File: rtl/rmau_ctl_reg.sv
module rmau_ctl_reg
  import rmau_pkg::*;
#(
  parameter int AW = IO_AW,
  parameter int DW = IO_DW,
  parameter logic [AW-1:0] PORT = CTL_PORT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          gate_q,
  output logic          rst_pulse_q,
  output logic          wr_hit,
  output logic          rd_hit
);
  logic sel;
  logic [DW-1:0] unused_wbits;

  assign sel    = (addr == PORT);
  assign wr_hit = wr & sel;
  assign rd_hit = rd & sel;
  assign unused_wbits = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q      <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      if (wr_hit) gate_q <= wdata[GATE_BIT];
      rst_pulse_q <= wr_hit & wdata[RSTRQ_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) rdata = ctl_readback(gate_q);
  end
endmodule

// File: rtl/rmau_lin_gen.sv
module rmau_lin_gen
  import rmau_pkg::*;
(
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic             gate_open,
  output logic [LIN_W-1:0] raw_sum,
  output logic [LIN_W-1:0] lin
);
  assign raw_sum = form_linear(seg, off);

  for (genvar b = 0; b < LIN_W; b++) begin : g_bit
    if (b == WRAP_BIT) begin : g_gated
      assign lin[b] = raw_sum[b] & gate_open;
    end else begin : g_pass
      assign lin[b] = raw_sum[b];
    end
  end
endmodule

// File: rtl/rm_addr_unit.sv
module rm_addr_unit
  import rmau_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEG_W-1:0]    seg_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [IO_AW-1:0]    io_addr_i,
  input  logic                io_wr_i,
  input  logic                io_rd_i,
  input  logic [IO_DW-1:0]    io_wdata_i,
  output logic [IO_DW-1:0]    io_rdata_o,
  output logic [LIN_W-1:0]    lin_addr_o,
  output logic                a20_en_o,
  output logic                fast_rst_o
);
  logic             gate_q;
  logic             wr_hit;
  logic             rd_hit;
  logic [LIN_W-1:0] raw_sum;

  rmau_ctl_reg i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (io_addr_i),
    .wr         (io_wr_i),
    .rd         (io_rd_i),
    .wdata      (io_wdata_i),
    .rdata      (io_rdata_o),
    .gate_q     (gate_q),
    .rst_pulse_q(fast_rst_o),
    .wr_hit     (wr_hit),
    .rd_hit     (rd_hit)
  );

  rmau_lin_gen i_lin (
    .seg      (seg_i),
    .off      (off_i),
    .gate_open(gate_q),
    .raw_sum  (raw_sum),
    .lin      (lin_addr_o)
  );

  assign a20_en_o = gate_q;
endmodule

// File: rtl/rm_addr_chk.sv
module rm_addr_chk
  import rmau_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_hit,
  input logic             rd_hit,
  input logic [IO_DW-1:0] wdata,
  input logic [IO_DW-1:0] rdata,
  input logic [LIN_W-1:0] raw_sum,
  input logic [LIN_W-1:0] lin,
  input logic             a20,
  input logic             frst
);
  // R2
  wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a20 |-> (lin[WRAP_BIT] == 1'b0));
  // R1
  open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a20 |-> (lin == raw_sum));
  // R4
  gate_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (a20 == $past(wdata[GATE_BIT])));
  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(a20));
  // R5
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frst) |-> $past(wr_hit));
  // R5
  pulse_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[RSTRQ_BIT]) |=> frst);
  // R6
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[RSTRQ_BIT] == 1'b0) && (rdata[IO_DW-1:GATE_BIT+1] == '0));
  // R6
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rdata == '0));
endmodule

bind rm_addr_unit rm_addr_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_hit (wr_hit),
  .rd_hit (rd_hit),
  .wdata  (io_wdata_i),
  .rdata  (io_rdata_o),
  .raw_sum(raw_sum),
  .lin    (lin_addr_o),
  .a20    (a20_en_o),
  .frst   (fast_rst_o)
);

// File: tb/test_rm_addr_unit.sv
module test_rm_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] seg_i = '0;
  logic [15:0] off_i = '0;
  logic [15:0] io_addr_i = '0;
  logic        io_wr_i = 1'b0;
  logic        io_rd_i = 1'b0;
  logic [7:0]  io_wdata_i = '0;
  logic [7:0]  io_rdata_o;
  logic [20:0] lin_addr_o;
  logic        a20_en_o;
  logic        fast_rst_o;

  int n_run = 0;
  int n_bad = 0;
  bit model_gate = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rm_addr_unit i_rm_addr_unit (
    .clk(clk), .rst_n(rst_n), .seg_i(seg_i), .off_i(off_i),
    .io_addr_i(io_addr_i), .io_wr_i(io_wr_i), .io_rd_i(io_rd_i),
    .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o),
    .lin_addr_o(lin_addr_o), .a20_en_o(a20_en_o), .fast_rst_o(fast_rst_o)
  );

  function automatic logic [20:0] want_lin(input logic [15:0] s, input logic [15:0] o, input bit g);
    int unsigned full;
    full = int'(s) * 16 + int'(o);
    if (!g) full = full % 32'h100000;
    return full[20:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [15:0] s, input logic [15:0] o, input string req);
    @(negedge clk);
    seg_i = s; off_i = o;
    #1;
    check(req, 32'(lin_addr_o), 32'(want_lin(s, o, model_gate)));
  endtask

  // One write cycle; checks gate and pulse after the edge, and the drop one cycle later.
  task automatic port_wr(input logic [15:0] a, input logic [7:0] d, input string req);
    bit hit;
    hit = (a == 16'h0092);
    @(negedge clk);
    io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    @(posedge clk); #1;
    if (hit) model_gate = d[1];
    check(req, 32'(a20_en_o), 32'(model_gate));
    check(req, 32'(fast_rst_o), 32'(hit & d[0]));
    @(negedge clk);
    io_wr_i = 1'b0;
    @(posedge clk); #1;
    check("R5", 32'(fast_rst_o), 32'd0);
  endtask

  task automatic port_rd(input logic [15:0] a, input string req);
    @(negedge clk);
    io_addr_i = a; io_rd_i = 1'b1;
    #1;
    check(req, 32'(io_rdata_o), (a == 16'h0092) ? 32'(model_gate) << 1 : 32'd0);
    @(negedge clk);
    io_rd_i = 1'b0;
    #1;
    check("R6", 32'(io_rdata_o), 32'd0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!finished) begin
      n_run++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_0092));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R3 reset state
    check("R3", 32'(a20_en_o), 32'd0);
    check("R3", 32'(fast_rst_o), 32'd0);
    port_rd(16'h0092, "R3");

    // R2 wrap with gate closed
    probe(16'hFFFF, 16'h0010, "R2");
    probe(16'hFFFF, 16'hFFFF, "R2");
    check("R2", 32'(lin_addr_o), 32'h0FFEF);
    // R8 aliasing
    probe(16'h0000, 16'h7C00, "R8");
    check("R8", 32'(lin_addr_o), 32'h07C00);
    probe(16'h07C0, 16'h0000, "R8");
    check("R8", 32'(lin_addr_o), 32'h07C00);

    // R7 other address, upper data bits
    port_wr(16'h0093, 8'h03, "R7");
    port_wr(16'h0192, 8'h03, "R7");
    port_wr(16'h0092, 8'hFC, "R7");
    check("R7", 32'(a20_en_o), 32'd0);
    port_wr(16'h0092, 8'hFD, "R7");

    // R4 open the gate without reset request
    port_wr(16'h0092, 8'h02, "R4");
    port_rd(16'h0092, "R6");
    port_rd(16'h0061, "R6");
    // R1 full sums
    probe(16'hFFFF, 16'h0010, "R1");
    check("R1", 32'(lin_addr_o), 32'h100000);
    probe(16'hFFFF, 16'hFFFF, "R1");
    check("R1", 32'(lin_addr_o), 32'h10FFEF);
    probe(16'h07C0, 16'h0000, "R8");

    // R5 reset request with gate set, then cleared
    port_wr(16'h0092, 8'h03, "R5");
    port_wr(16'h0092, 8'h01, "R5");
    check("R5", 32'(a20_en_o), 32'd0);
    probe(16'hF800, 16'h8000, "R2");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned pick;
      pick = $urandom % 10;
      if (pick == 0)
        port_wr(($urandom % 4 == 0) ? 16'(($urandom % 256)) : 16'h0092, 8'($urandom), "R4");
      else if (pick == 1)
        port_rd(($urandom % 3 == 0) ? 16'h0090 : 16'h0092, "R6");
      else
        probe(16'($urandom), 16'($urandom), model_gate ? "R1" : "R2");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule